// File: doc/BRIEF.md
# Conversion Result Post-Processing Engine

This block sits behind an analog-to-digital converter and works on its stream of conversion results, one result per trigger. A selectable mode decides what happens to each result. In bypass nothing is kept. The other modes keep a running sum, keep a mean over a programmed number of samples, keep bursts of such means, or run a first-order lowpass recursion. A 16-bit two's-complement accumulator and a saturating sample counter hold the state. A 3-bit shift amount is used as a scale factor, as the divisor for the mean, or as the filter cutoff, depending on the mode.

When a mode reaches its completion condition, the block pulses a strobe for one cycle. This strobe tells a downstream threshold comparator to evaluate the shifted result. A sticky flag records an accumulator carry. A clear request zeroes the state, and the clear sequence then occupies the block for a fixed number of cycles. Triggers that arrive during that sequence are dropped.

Top module: `smpacc_top`

## Requirements
- R1: After reset, `acc_out`, `cnt_out`, `ovf`, `thr_strobe` and `clr_busy` are all zero.
- R2: In mode 3'b000 (bypass), a valid result leaves the accumulator, the counter and the flag unchanged, and `thr_strobe` stays low.
- R3: In mode 3'b001 (accumulate), each result is shifted right by `shift` and then added to the accumulator. The counter increments. `result_out` equals the accumulator. `thr_strobe` pulses in the cycle after every accepted result.
- R4: In mode 3'b010 (average), each raw result is added and the counter increments. `thr_strobe` pulses only when the new count is greater than or equal to `rpt`. `result_out` is the accumulator arithmetically shifted right by `shift`.
- R5: In the two averaging modes, a result that arrives while the count is already at or above `rpt` restarts the window. The accumulator is loaded with that result and the counter is set to 1.
- R6: Mode 3'b011 (burst average) accumulates, restarts and strobes exactly as average mode does.
- R7: In mode 3'b100 (lowpass), each result sets acc = acc + sample - (acc >> shift), using a logical shift of the stored value. `result_out` is acc >>> shift. `thr_strobe` pulses after every result.
- R8: When an update's unsigned 17-bit sum exceeds 16'hFFFF, the accumulator keeps the low 16 bits. `ovf` is then set, and it stays set until a clear.
- R9: The sample counter saturates at its all-ones value and does not wrap.
- R10: A cycle with `clr_req` high zeroes the accumulator, the counter and `ovf`. `clr_busy` then stays high for CLR_CYCLES (5) cycles. Results offered in the request cycle or while busy are ignored.
- R11: Codes 3'b101 to 3'b111 behave as bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe (trigger) |
| res_data | input | RES_W (12) | Unsigned conversion result |
| mode | input | 3 | Processing mode select |
| rpt | input | CNT_W (8) | Repeat count for averaging |
| shift | input | SHIFT_W (3) | Right-shift amount |
| clr_req | input | 1 | Clear request |
| acc_out | output | ACC_W (16) | Accumulator contents |
| cnt_out | output | CNT_W (8) | Sample counter |
| result_out | output | ACC_W (16) | Mode-dependent shifted result |
| thr_strobe | output | 1 | Threshold evaluation pulse |
| ovf | output | 1 | Sticky accumulator carry flag |
| clr_busy | output | 1 | Clear sequence in progress |

## Verification
The bench targets the average window boundary. A design that compares with the wrong inequality would strobe one sample early, or fail to restart and keep summing past `rpt`. The bench pushes the accumulator across 16'hFFFF. A design that wraps silently would leave `ovf` low, and a design that clamps would show the wrong low bits. It also drives more than 255 samples to catch a counter that wraps back to zero. It offers results during the clear window, where a design that accepts them early would show a nonzero count.

// File: rtl/smpacc_pkg.sv
package smpacc_pkg;
   typedef enum logic [2:0] {
      MD_BYPASS  = 3'b000,
      MD_ACCUM   = 3'b001,
      MD_AVG     = 3'b010,
      MD_BURST   = 3'b011,
      MD_LOWPASS = 3'b100
   } smp_mode_e;

   function automatic logic is_avg_like(input logic [2:0] m);
      return (m == MD_AVG) || (m == MD_BURST);
   endfunction
endpackage

// File: rtl/smpacc_clr_seq.sv
module smpacc_clr_seq #(
   parameter int CLR_CYCLES = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_req,
   output logic busy
);
   localparam int BW = (CLR_CYCLES < 2) ? 1 : $clog2(CLR_CYCLES + 1);

   generate
      if (CLR_CYCLES == 0) begin : g_instant
         assign busy = 1'b0;
      end else begin : g_timed
         logic [BW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                left_q <= '0;
            else if (clr_req)          left_q <= BW'(CLR_CYCLES);
            else if (left_q != '0)     left_q <= left_q - 1'b1;
         end
         assign busy = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/smpacc_counter.sv
module smpacc_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic             restart,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clear)          cnt <= '0;
      else if (restart)        cnt <= CNT_W'(1);
      else if (step && cnt != TOP) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/smpacc_update.sv
module smpacc_update
   import smpacc_pkg::*;
#(
   parameter int ACC_W   = 16,
   parameter int RES_W   = 12,
   parameter int CNT_W   = 8,
   parameter int SHIFT_W = 3
) (
   input  logic [ACC_W-1:0]   acc,
   input  logic [RES_W-1:0]   sample,
   input  logic [2:0]         mode,
   input  logic [SHIFT_W-1:0] shift,
   input  logic [CNT_W-1:0]   cnt,
   input  logic [CNT_W-1:0]   rpt,
   output logic               active,
   output logic               restart,
   output logic               fire,
   output logic               carry,
   output logic [ACC_W-1:0]   acc_nxt
);
   localparam int EXT = ACC_W + 1;
   localparam logic [CNT_W-1:0] TOP = '1;

   logic [EXT-1:0] acc_x, smp_x, sum_x;
   logic [CNT_W-1:0] cnt_after;

   assign acc_x = {1'b0, acc};
   assign smp_x = EXT'(sample);

   always_comb begin
      active  = 1'b0;
      restart = 1'b0;
      sum_x   = acc_x;
      case (mode)
         MD_ACCUM: begin
            active = 1'b1;
            sum_x  = acc_x + (smp_x >> shift);
         end
         MD_AVG, MD_BURST: begin
            active  = 1'b1;
            restart = (cnt >= rpt);
            sum_x   = restart ? smp_x : acc_x + smp_x;
         end
         MD_LOWPASS: begin
            active = 1'b1;
            sum_x  = acc_x + smp_x - (acc_x >> shift);
         end
         default: ;
      endcase
   end

   assign carry     = active & sum_x[ACC_W];
   assign acc_nxt   = sum_x[ACC_W-1:0];
   assign cnt_after = restart ? CNT_W'(1) : ((cnt == TOP) ? cnt : cnt + 1'b1);
   assign fire      = active & (is_avg_like(mode) ? (cnt_after >= rpt) : 1'b1);
endmodule

// File: rtl/smpacc_top.sv
module smpacc_top
   import smpacc_pkg::*;
#(
   parameter int ACC_W      = 16,
   parameter int RES_W      = 12,
   parameter int CNT_W      = 8,
   parameter int SHIFT_W    = 3,
   parameter int CLR_CYCLES = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               res_valid,
   input  logic [RES_W-1:0]   res_data,
   input  logic [2:0]         mode,
   input  logic [CNT_W-1:0]   rpt,
   input  logic [SHIFT_W-1:0] shift,
   input  logic               clr_req,
   output logic [ACC_W-1:0]   acc_out,
   output logic [CNT_W-1:0]   cnt_out,
   output logic [ACC_W-1:0]   result_out,
   output logic               thr_strobe,
   output logic               ovf,
   output logic               clr_busy
);
   if (ACC_W <= RES_W) begin : g_bad_width
      $error("ACC_W must exceed RES_W");
   end
   if (SHIFT_W < 1 || SHIFT_W > 4) begin : g_bad_shift
      $error("SHIFT_W out of range");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W too small");
   end

   logic take, active, restart, fire, carry;
   logic [ACC_W-1:0] acc_q, acc_nxt;

   smpacc_clr_seq #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
      .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .busy(clr_busy));

   assign take = res_valid & ~clr_req & ~clr_busy;

   smpacc_update #(.ACC_W(ACC_W), .RES_W(RES_W), .CNT_W(CNT_W),
                   .SHIFT_W(SHIFT_W)) u_upd (
      .acc(acc_q), .sample(res_data), .mode(mode), .shift(shift),
      .cnt(cnt_out), .rpt(rpt), .active(active), .restart(restart),
      .fire(fire), .carry(carry), .acc_nxt(acc_nxt));

   smpacc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(clr_req),
      .step(take & active), .restart(take & restart), .cnt(cnt_out));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q      <= '0;
         ovf        <= 1'b0;
         thr_strobe <= 1'b0;
      end else if (clr_req) begin
         acc_q      <= '0;
         ovf        <= 1'b0;
         thr_strobe <= 1'b0;
      end else begin
         thr_strobe <= take & fire;
         if (take & active) acc_q <= acc_nxt;
         if (take & carry)  ovf   <= 1'b1;
      end
   end

   logic signed [ACC_W-1:0] acc_s;
   assign acc_s   = acc_q;
   assign acc_out = acc_q;

   always_comb begin
      case (mode)
         MD_AVG, MD_BURST, MD_LOWPASS: result_out = ACC_W'(acc_s >>> shift);
         default:                      result_out = acc_q;
      endcase
   end
endmodule

// File: rtl/smpacc_chk.sv
module smpacc_chk #(
   parameter int ACC_W = 16,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             res_valid,
   input logic [2:0]       mode,
   input logic             clr_req,
   input logic [ACC_W-1:0] acc_out,
   input logic [CNT_W-1:0] cnt_out,
   input logic             thr_strobe,
   input logic             ovf,
   input logic             clr_busy
);
   p_strobe_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      thr_strobe |-> $past(res_valid));
   p_bypass_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      thr_strobe |-> ($past(mode) inside {3'b001, 3'b010, 3'b011, 3'b100}));
   p_clear_zeroes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_req) |-> (acc_out == '0 && cnt_out == '0 && !ovf && !thr_strobe));
   p_busy_holds_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_busy) |-> (acc_out == '0 && cnt_out == '0 && !thr_strobe));
   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ovf) && !$past(clr_req)) |-> ovf);
   p_cnt_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_out) == '1 && !$past(clr_req) &&
       ($past(mode) == 3'b001 || $past(mode) == 3'b100)) |-> (cnt_out == '1));
endmodule

bind smpacc_top smpacc_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .mode(mode),
   .clr_req(clr_req), .acc_out(acc_out), .cnt_out(cnt_out),
   .thr_strobe(thr_strobe), .ovf(ovf), .clr_busy(clr_busy));

// File: tb/tb_smpacc_top.sv
`timescale 1ns/1ps
module tb_smpacc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [11:0] res_data = '0;
   logic [2:0]  mode = 3'b000;
   logic [7:0]  rpt = 8'd0;
   logic [2:0]  shift = 3'd0;
   logic        clr_req = 1'b0;
   logic [15:0] acc_out, result_out;
   logic [7:0]  cnt_out;
   logic        thr_strobe, ovf, clr_busy;

   int n_chk = 0;
   int n_bad = 0;
   int m_acc, m_cnt, m_ovf, m_stb;

   always #2.5 clk = ~clk;

   smpacc_top dut (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
      .mode(mode), .rpt(rpt), .shift(shift), .clr_req(clr_req),
      .acc_out(acc_out), .cnt_out(cnt_out), .result_out(result_out),
      .thr_strobe(thr_strobe), .ovf(ovf), .clr_busy(clr_busy));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // bench model of one accepted result, written from R2..R9
   task automatic push(input int s);
      int sum;
      m_stb = 0;
      sum = m_acc;
      case (mode)
         3'b001: begin sum = m_acc + (s >> shift); m_stb = 1;
                       m_cnt = (m_cnt == 255) ? 255 : m_cnt + 1; end
         3'b010, 3'b011: begin
            if (m_cnt >= rpt) begin sum = s; m_cnt = 1; end
            else begin sum = m_acc + s; m_cnt = (m_cnt == 255) ? 255 : m_cnt + 1; end
            m_stb = (m_cnt >= rpt);
         end
         3'b100: begin sum = m_acc + s - (m_acc >> shift); m_stb = 1;
                       m_cnt = (m_cnt == 255) ? 255 : m_cnt + 1; end
         default: ;
      endcase
      if (sum > 65535) m_ovf = 1;
      m_acc = sum & 16'hFFFF;
      @(negedge clk); res_valid = 1'b1; res_data = 12'(s);
      @(negedge clk); res_valid = 1'b0;
   endtask

   task automatic compare(input string tag);
      chk({tag, " acc"}, acc_out, m_acc);
      chk({tag, " cnt"}, cnt_out, m_cnt);
      chk({tag, " ovf"}, ovf, m_ovf);
      chk({tag, " strobe"}, thr_strobe, m_stb);
   endtask

   task automatic do_clear();
      @(negedge clk); clr_req = 1'b1;
      @(negedge clk); clr_req = 1'b0;
      while (clr_busy) @(negedge clk);
      m_acc = 0; m_cnt = 0; m_ovf = 0; m_stb = 0;
   endtask

   task automatic t_reset();
      chk("R1 acc", acc_out, 0);
      chk("R1 cnt", cnt_out, 0);
      chk("R1 ovf", ovf, 0);
      chk("R1 strobe", thr_strobe, 0);
      chk("R1 busy", clr_busy, 0);
   endtask

   task automatic t_accum();
      do_clear(); mode = 3'b001; shift = 3'd2;
      push(100); compare("R3 s1");
      push(7);   compare("R3 s2");
      chk("R3 result", result_out, 26);
   endtask

   task automatic t_bypass();
      mode = 3'b000; push(500); compare("R2 bypass");
      mode = 3'b111; push(500); compare("R11 code7");
      mode = 3'b101; push(321); compare("R11 code5");
   endtask

   task automatic t_average();
      do_clear(); mode = 3'b010; rpt = 8'd4; shift = 3'd2;
      push(10); compare("R4 a1");
      push(20); compare("R4 a2");
      push(30); compare("R4 a3");
      push(40); compare("R4 a4");
      chk("R4 mean", result_out, 25);
      push(8);  compare("R5 restart");
      chk("R5 cnt one", cnt_out, 1);
   endtask

   task automatic t_burst();
      do_clear(); mode = 3'b011; rpt = 8'd2; shift = 3'd1;
      push(6);  compare("R6 b1");
      push(10); compare("R6 b2");
      chk("R6 mean", result_out, 8);
      push(50); compare("R6 restart");
   endtask

   task automatic t_lowpass();
      do_clear(); mode = 3'b100; shift = 3'd2;
      for (int i = 0; i < 6; i++) begin
         push(1000); compare("R7 lp");
      end
      chk("R7 result", result_out, m_acc >> 2);
   endtask

   task automatic t_overflow();
      do_clear(); mode = 3'b001; shift = 3'd0;
      for (int i = 0; i < 16; i++) push(4095);
      compare("R8 before");
      push(4095); compare("R8 carry");
      push(1);    compare("R8 sticky");
   endtask

   task automatic t_saturate();
      do_clear(); mode = 3'b001; shift = 3'd7;
      for (int i = 0; i < 258; i++) push(0);
      compare("R9 sat");
      chk("R9 cnt top", cnt_out, 255);
   endtask

   task automatic t_clear();
      mode = 3'b001; shift = 3'd0;
      push(9); push(9);
      @(negedge clk); clr_req = 1'b1; res_valid = 1'b1; res_data = 12'd3;
      @(negedge clk); clr_req = 1'b0;
      chk("R10 acc zero", acc_out, 0);
      chk("R10 cnt zero", cnt_out, 0);
      for (int i = 0; i < 5; i++) begin
         chk("R10 busy", clr_busy, 1);
         @(negedge clk);
      end
      res_valid = 1'b0;
      chk("R10 busy done", clr_busy, 0);
      chk("R10 ignored", cnt_out, 0);
      m_acc = 0; m_cnt = 0; m_ovf = 0;
      push(3); compare("R10 after");
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      m_acc = 0; m_cnt = 0; m_ovf = 0; m_stb = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_accum();
      t_bypass();
      t_average();
      t_burst();
      t_lowpass();
      t_overflow();
      t_saturate();
      t_clear();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule